// File: doc/BRIEF.md
# Interval Timer Host Port and Snapshot Latches

This block is the 8-bit host-side front end of a three-channel interval timer. A two-bit address picks one of three per-channel data ports (addresses 0, 1, 2) or the shared command port (address 3). Command writes are sorted into three kinds: a channel setup command, a single-channel count snapshot, or a multi-channel read-back that can capture counts, status or both. Data-port writes become byte strobes toward the counting logic. Data-port reads return bytes of either the live count or a frozen snapshot.

Each channel keeps its own stored setup bits, its own write and read byte pointers, a count snapshot and a status snapshot. The counting engines sit outside this block. They supply the live 16-bit count, the output pin level and a pending flag, which is high while a newly written reload value has not yet reached the counter. The block returns one setup strobe and two reload byte strobes per channel.

Each channel has two two-state machines. The write machine has states `BP_LOW` and `BP_HIGH`: `BP_LOW` goes to `BP_HIGH` on a paired-mode data write, and `BP_HIGH` goes back to `BP_LOW` on the next one. The read machine uses the same states and moves the same way on paired-mode reads that return count bytes. A setup command forces both machines of its channel back to `BP_LOW`.

Top module: `tmr_host_if`

## Requirements
- R1: After reset no strobe is active, every channel holds setup bits 6'b110000 (paired access, low byte first), and both byte pointers point to the low byte. A data read then returns the live count low byte, then the high byte.
- R2: Addresses 0 to 2 select the data ports of channels 0 to 2, and address 3 selects the command port. A read at address 3 returns 8'h00 and changes nothing.
- R3: A command byte with select bits 7:6 in 0 to 2 and access bits 5:4 not 00 is a setup command. One cycle later it pulses `mode_wr` for that channel, with `mode_cfg` equal to bits 5:0. It stores those bits and returns both byte pointers of that channel to the low byte.
- R4: A data write pulses a reload strobe one cycle later, with `reload_byte` equal to the written byte. Access 01 pulses only the low strobe and access 10 pulses only the high strobe. Access 11 alternates between the low strobe and the high strobe, starting with the low strobe.
- R5: With no snapshot held, reads follow the same access rules on the live count. Access 01 always returns the low byte, access 10 always returns the high byte, and access 11 alternates low then high.
- R6: A command with access bits 00 captures the selected channel's live count at the command edge. Reads return bytes of that snapshot until it has been fully read, which takes one read for access 01 or 10 and two reads for access 11. Later reads return the live count again.
- R7: A count or status capture aimed at a channel whose matching snapshot is still unread is ignored, and the earlier snapshot is kept.
- R8: A setup command discards both snapshots of its channel.
- R9: Select bits 11 mark a read-back command. Bits 1, 2 and 3 select channels 0, 1 and 2, in any combination. Bit 5 = 0 captures the count and bit 4 = 0 captures the status. A read-back never pulses `mode_wr` and never alters the stored setup bits.
- R10: A status byte holds the output pin in bit 7, the pending flag in bit 6 and the stored setup bits in bits 5:0. When a status is held, the next read returns it, and the count bytes follow in access order.
- R11: Commands and accesses aimed at one channel leave the pointers, snapshots and setup bits of the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Host write strobe, one cycle per access |
| rd_en | input | 1 | Host read strobe, one cycle per access |
| addr | input | 2 | Port select: 0 to 2 data, 3 command |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte for the addressed port, combinational |
| ch_count | input | 48 | Live counts, channel c in bits 16c+15:16c |
| ch_out | input | 3 | Output pin level per channel |
| ch_pend | input | 3 | Reload value written but not yet loaded, per channel |
| mode_wr | output | 3 | Setup strobe per channel |
| mode_cfg | output | 6 | Setup bits that go with `mode_wr` |
| reload_lo_wr | output | 3 | Reload low-byte strobe per channel |
| reload_hi_wr | output | 3 | Reload high-byte strobe per channel |
| reload_byte | output | 8 | Byte that goes with the reload strobes |

## Verification
Read data comes straight from a multiplexer. It is due in the same cycle as `rd_en`, and the byte pointer advances at the following edge. Setup and reload strobes come from registers and are due exactly one cycle after the write that causes them. Snapshots capture the live count and pin levels at the command's own edge, so the bench changes those inputs only after that edge. Every expected item carries the cycle number it is due in. The monitor compares it at the falling edge of that cycle, and an item left behind its cycle counts as a failure.

// File: rtl/tmr_host_pkg.sv
package tmr_host_pkg;
    localparam int BW       = 8;
    localparam int NCH      = 3;
    localparam int CW       = 2 * BW;
    localparam int CFG_W    = 6;
    localparam logic [1:0] CMD_ADDR = 2'd3;
    localparam logic [1:0] SEL_RDBK = 2'b11;
    localparam logic [CFG_W-1:0] CFG_RST = 6'b110000;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_PAIR  = 2'b11
    } acc_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_MODE,
        CMD_LATCH,
        CMD_RDBK
    } cmd_e;

    typedef enum logic {
        BP_LOW,
        BP_HIGH
    } bptr_e;
endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
    import tmr_host_pkg::*;
(
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [1:0]     addr,
    input  logic [7:1]     cmd_hi,
    output cmd_e           kind,
    output logic [NCH-1:0] hit,
    output logic           rb_cnt,
    output logic           rb_sts,
    output logic [NCH-1:0] data_wr,
    output logic [NCH-1:0] data_rd
);
    logic [1:0] sel;
    acc_e       acc;
    logic       cmd_wr;

    assign sel    = cmd_hi[7:6];
    assign acc    = acc_e'(cmd_hi[5:4]);
    assign cmd_wr = wr_en && (addr == CMD_ADDR);
    assign rb_cnt = !cmd_hi[5];
    assign rb_sts = !cmd_hi[4];

    always_comb begin
        if (!cmd_wr)              kind = CMD_NONE;
        else if (sel == SEL_RDBK) kind = CMD_RDBK;
        else if (acc == ACC_LATCH) kind = CMD_LATCH;
        else                      kind = CMD_MODE;
    end

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            localparam logic [1:0] IDX = 2'(c);
            assign hit[c]     = (kind == CMD_RDBK) ? cmd_hi[1+c] : (sel == IDX);
            assign data_wr[c] = wr_en && (addr == IDX);
            assign data_rd[c] = rd_en && (addr == IDX);
        end
    endgenerate
endmodule

// File: rtl/tmr_chan_port.sv
module tmr_chan_port
    import tmr_host_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             kind,
    input  logic             hit,
    input  logic             rb_cnt,
    input  logic             rb_sts,
    input  logic [CFG_W-1:0] cmd_bits,
    input  logic             data_wr,
    input  logic             data_rd,
    input  logic [CW-1:0]    live_count,
    input  logic             pin_out,
    input  logic             pend,
    output logic             mode_stb,
    output logic             lo_stb,
    output logic             hi_stb,
    output logic [BW-1:0]    rd_byte
);
    logic [CFG_W-1:0] cfg;
    acc_e             acc;
    bptr_e            wr_ptr, wr_nx, rd_ptr, rd_nx;
    logic             lo_nx, hi_nx;
    logic             cnt_vld, sts_vld;
    logic [CW-1:0]    cnt_lat;
    logic [BW-1:0]    sts_lat;
    logic             mode_cmd, take_cnt, take_sts;
    logic             hi_sel, last_byte;
    logic [CW-1:0]    src;

    assign acc      = acc_e'(cfg[5:4]);
    assign mode_cmd = (kind == CMD_MODE) && hit;
    assign take_cnt = hit && ((kind == CMD_LATCH) || ((kind == CMD_RDBK) && rb_cnt));
    assign take_sts = hit && (kind == CMD_RDBK) && rb_sts;

    // write byte sequencer
    always_comb begin
        wr_nx = wr_ptr;
        lo_nx = 1'b0;
        hi_nx = 1'b0;
        if (mode_cmd) begin
            wr_nx = BP_LOW;
        end else if (data_wr) begin
            unique case (acc)
                ACC_LO: lo_nx = 1'b1;
                ACC_HI: hi_nx = 1'b1;
                ACC_PAIR: begin
                    unique case (wr_ptr)
                        BP_LOW:  begin lo_nx = 1'b1; wr_nx = BP_HIGH; end
                        BP_HIGH: begin hi_nx = 1'b1; wr_nx = BP_LOW;  end
                    endcase
                end
                default: ;
            endcase
        end
    end

    // read byte sequencer
    assign hi_sel    = (acc == ACC_HI) || ((acc == ACC_PAIR) && (rd_ptr == BP_HIGH));
    assign last_byte = (acc != ACC_PAIR) || (rd_ptr == BP_HIGH);
    assign src       = cnt_vld ? cnt_lat : live_count;
    assign rd_byte   = sts_vld ? sts_lat : (hi_sel ? src[CW-1:BW] : src[BW-1:0]);

    always_comb begin
        rd_nx = rd_ptr;
        if (mode_cmd) begin
            rd_nx = BP_LOW;
        end else if (data_rd && !sts_vld && (acc == ACC_PAIR)) begin
            unique case (rd_ptr)
                BP_LOW:  rd_nx = BP_HIGH;
                BP_HIGH: rd_nx = BP_LOW;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= BP_LOW;
            rd_ptr <= BP_LOW;
            cfg    <= CFG_RST;
        end else begin
            wr_ptr <= wr_nx;
            rd_ptr <= rd_nx;
            if (mode_cmd) cfg <= cmd_bits;
        end
    end

    // snapshot latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_vld <= 1'b0;
            sts_vld <= 1'b0;
            cnt_lat <= '0;
            sts_lat <= '0;
        end else if (mode_cmd) begin
            cnt_vld <= 1'b0;
            sts_vld <= 1'b0;
        end else begin
            if (data_rd) begin
                if (sts_vld)        sts_vld <= 1'b0;
                else if (last_byte) cnt_vld <= 1'b0;
            end
            if (take_cnt && !cnt_vld) begin
                cnt_vld <= 1'b1;
                cnt_lat <= live_count;
            end
            if (take_sts && !sts_vld) begin
                sts_vld <= 1'b1;
                sts_lat <= {pin_out, pend, cfg};
            end
        end
    end

    // registered strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_stb <= 1'b0;
            lo_stb   <= 1'b0;
            hi_stb   <= 1'b0;
        end else begin
            mode_stb <= mode_cmd;
            lo_stb   <= lo_nx;
            hi_stb   <= hi_nx;
        end
    end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
    import tmr_host_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [1:0]         addr,
    input  logic [BW-1:0]      wdata,
    output logic [BW-1:0]      rdata,
    input  logic [NCH*CW-1:0]  ch_count,
    input  logic [NCH-1:0]     ch_out,
    input  logic [NCH-1:0]     ch_pend,
    output logic [NCH-1:0]     mode_wr,
    output logic [CFG_W-1:0]   mode_cfg,
    output logic [NCH-1:0]     reload_lo_wr,
    output logic [NCH-1:0]     reload_hi_wr,
    output logic [BW-1:0]      reload_byte
);
    cmd_e           kind;
    logic [NCH-1:0] hit, data_wr, data_rd;
    logic           rb_cnt, rb_sts;
    logic [BW-1:0]  rd_byte [NCH];

    tmr_cmd_decode u_dec (
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .cmd_hi  (wdata[7:1]),
        .kind    (kind),
        .hit     (hit),
        .rb_cnt  (rb_cnt),
        .rb_sts  (rb_sts),
        .data_wr (data_wr),
        .data_rd (data_rd)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            tmr_chan_port u_chan (
                .clk        (clk),
                .rst_n      (rst_n),
                .kind       (kind),
                .hit        (hit[c]),
                .rb_cnt     (rb_cnt),
                .rb_sts     (rb_sts),
                .cmd_bits   (wdata[CFG_W-1:0]),
                .data_wr    (data_wr[c]),
                .data_rd    (data_rd[c]),
                .live_count (ch_count[c*CW +: CW]),
                .pin_out    (ch_out[c]),
                .pend       (ch_pend[c]),
                .mode_stb   (mode_wr[c]),
                .lo_stb     (reload_lo_wr[c]),
                .hi_stb     (reload_hi_wr[c]),
                .rd_byte    (rd_byte[c])
            );
        end
    endgenerate

    always_comb begin
        unique case (addr)
            2'd0:    rdata = rd_byte[0];
            2'd1:    rdata = rd_byte[1];
            2'd2:    rdata = rd_byte[2];
            default: rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_cfg    <= '0;
            reload_byte <= '0;
        end else begin
            if (kind == CMD_MODE) mode_cfg <= wdata[CFG_W-1:0];
            if (|data_wr)         reload_byte <= wdata;
        end
    end
endmodule

// File: rtl/tmr_host_chk.sv
module tmr_host_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic       rd_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic [2:0] mode_wr,
    input logic [2:0] reload_lo_wr,
    input logic [2:0] reload_hi_wr
);
    generate
        for (genvar c = 0; c < 3; c++) begin : g_a
            localparam logic [1:0] IDX = 2'(c);
            // R4: low reload strobe only after a data write to that port
            p_lo_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
                reload_lo_wr[c] |-> $past(wr_en && (addr == IDX)));
            // R4: high reload strobe only after a data write to that port
            p_hi_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
                reload_hi_wr[c] |-> $past(wr_en && (addr == IDX)));
            // R3: setup strobe only after a setup command for that channel
            p_mode_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
                mode_wr[c] |-> $past(wr_en && (addr == 2'd3) && (wdata[7:6] == IDX)
                                     && (wdata[5:4] != 2'b00)));
        end
    endgenerate

    // R4: at most one strobe per access
    p_single_stb_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_wr, reload_lo_wr, reload_hi_wr}));

    // R2: a read alone produces no strobe
    p_read_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> ((mode_wr == 3'b0) && (reload_lo_wr == 3'b0)
                               && (reload_hi_wr == 3'b0)));

    // R9: a read-back never pulses a setup strobe
    p_rdbk_no_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == 2'd3) && (wdata[7:6] == 2'b11)) |=> (mode_wr == 3'b0));
endmodule

bind tmr_host_if tmr_host_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .mode_wr      (mode_wr),
    .reload_lo_wr (reload_lo_wr),
    .reload_hi_wr (reload_hi_wr)
);

// File: tb/tmr_host_if_tb_top.sv
module tmr_host_if_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [15:0] cnt0 = 16'h1234, cnt1 = 16'hA55A, cnt2 = 16'h0F0E;
    logic [2:0]  ch_out = 3'b000;
    logic [2:0]  ch_pend = 3'b000;
    logic [2:0]  mode_wr, reload_lo_wr, reload_hi_wr;
    logic [5:0]  mode_cfg;
    logic [7:0]  reload_byte;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    localparam int K_RD  = 0;
    localparam int K_STB = 1;

    typedef struct {
        int         due;
        int         kind;
        logic [8:0] stb;
        logic [7:0] val;
        string      req;
    } item_t;

    item_t sb[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    tmr_host_if dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_en        (rd_en),
        .addr         (addr),
        .wdata        (wdata),
        .rdata        (rdata),
        .ch_count     ({cnt2, cnt1, cnt0}),
        .ch_out       (ch_out),
        .ch_pend      (ch_pend),
        .mode_wr      (mode_wr),
        .mode_cfg     (mode_cfg),
        .reload_lo_wr (reload_lo_wr),
        .reload_hi_wr (reload_hi_wr),
        .reload_byte  (reload_byte)
    );

    // monitor: compares queued items in the cycle they are due
    always @(negedge clk) begin
        logic [8:0] got;
        got = {mode_wr, reload_hi_wr, reload_lo_wr};
        while (sb.size() > 0 && sb[0].due <= cyc) begin
            item_t it;
            it = sb.pop_front();
            total++;
            if (it.due < cyc) begin
                bad++;
                $display("FAIL %s: item missed, got cycle %0d exp cycle %0d", it.req, cyc, it.due);
            end else if (it.kind == K_RD) begin
                if (rdata !== it.val) begin
                    bad++;
                    $display("FAIL %s: rdata got %h exp %h", it.req, rdata, it.val);
                end
            end else begin
                if (got !== it.stb) begin
                    bad++;
                    $display("FAIL %s: strobes got %b exp %b", it.req, got, it.stb);
                end else if (|it.stb[8:6] && mode_cfg !== it.val[5:0]) begin
                    bad++;
                    $display("FAIL %s: mode_cfg got %h exp %h", it.req, mode_cfg, it.val[5:0]);
                end else if (|it.stb[5:0] && reload_byte !== it.val) begin
                    bad++;
                    $display("FAIL %s: reload_byte got %h exp %h", it.req, reload_byte, it.val);
                end
            end
        end
    end

    task automatic push(input int due, input int kind, input logic [8:0] stb,
                        input logic [7:0] val, input string req);
        item_t it;
        it.due = due; it.kind = kind; it.stb = stb; it.val = val; it.req = req;
        sb.push_back(it);
    endtask

    task automatic t_cmd(input logic [7:0] b, input logic [8:0] stb, input string req);
        @(posedge clk); #1;
        wr_en = 1'b1; rd_en = 1'b0; addr = 2'd3; wdata = b;
        push(cyc + 1, K_STB, stb, {2'b00, b[5:0]}, req);
    endtask

    task automatic t_wr(input int ch, input logic [7:0] b, input logic [8:0] stb, input string req);
        @(posedge clk); #1;
        wr_en = 1'b1; rd_en = 1'b0; addr = 2'(ch); wdata = b;
        push(cyc + 1, K_STB, stb, b, req);
    endtask

    task automatic t_rd(input int ch, input logic [7:0] exp, input string req);
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b1; addr = 2'(ch); wdata = 8'h00;
        push(cyc, K_RD, 9'b0, exp, req);
        push(cyc + 1, K_STB, 9'b0, 8'h00, req);
    endtask

    task automatic t_idle;
        @(posedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    endtask

    // watchdog
    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, paired live read of channel 0
        t_rd(0, 8'h34, "R1");
        t_rd(0, 8'h12, "R1");
        // R3: setup ch0, low-only, mode bits 6'h14
        t_cmd(8'h14, 9'b001_000_000, "R3");
        // R4: low-only writes
        t_wr(0, 8'hAB, 9'b000_000_001, "R4");
        t_wr(0, 8'hCD, 9'b000_000_001, "R4");
        // R5: low-only reads repeat the low byte
        t_rd(0, 8'h34, "R5");
        t_rd(0, 8'h34, "R5");
        // R3/R4/R5: ch1 high-only
        t_cmd(8'h66, 9'b010_000_000, "R3");
        t_wr(1, 8'h77, 9'b000_010_000, "R4");
        t_rd(1, 8'hA5, "R5");
        // R4: ch2 paired writes alternate
        t_cmd(8'hB6, 9'b100_000_000, "R3");
        t_wr(2, 8'h11, 9'b000_000_100, "R4");
        t_wr(2, 8'h22, 9'b000_100_000, "R4");
        t_wr(2, 8'h33, 9'b000_000_100, "R4");
        // R3: setup resets the write pointer
        t_cmd(8'hB6, 9'b100_000_000, "R3");
        t_wr(2, 8'h44, 9'b000_000_100, "R3");
        t_wr(2, 8'h55, 9'b000_100_000, "R4");
        // R6: count latch on ch2
        t_cmd(8'h80, 9'b0, "R6");
        t_idle;
        cnt2 = 16'h0707;
        t_rd(2, 8'h0E, "R6");
        // R7: second latch while unread is ignored
        t_cmd(8'h80, 9'b0, "R7");
        t_idle;
        cnt2 = 16'h0303;
        t_rd(2, 8'h0F, "R7");
        t_rd(2, 8'h03, "R6");
        t_rd(2, 8'h03, "R6");
        // R8: setup discards a pending snapshot
        t_cmd(8'h80, 9'b0, "R8");
        t_idle;
        cnt2 = 16'h1111;
        t_cmd(8'hB6, 9'b100_000_000, "R8");
        t_rd(2, 8'h11, "R8");
        t_rd(2, 8'h11, "R8");
        // R9/R10: read-back count and status of ch0 and ch2
        ch_out = 3'b001; ch_pend = 3'b100;
        t_cmd(8'hCA, 9'b0, "R9");
        t_idle;
        cnt0 = 16'h5555; cnt2 = 16'h2222; ch_out = 3'b100; ch_pend = 3'b000;
        t_rd(0, 8'h94, "R10");
        t_rd(0, 8'h34, "R9");
        t_rd(0, 8'h55, "R9");
        t_rd(2, 8'h76, "R10");
        t_rd(2, 8'h11, "R9");
        t_rd(2, 8'h11, "R9");
        t_rd(2, 8'h22, "R9");
        t_rd(2, 8'h22, "R9");
        // R11: ch1 untouched by the above
        t_rd(1, 8'hA5, "R11");
        // R10/R7: status-only read-back of ch1, repeat ignored
        ch_out = 3'b010; ch_pend = 3'b010;
        t_cmd(8'hE4, 9'b0, "R10");
        t_idle;
        ch_out = 3'b000; ch_pend = 3'b000;
        t_cmd(8'hE4, 9'b0, "R7");
        t_rd(1, 8'hE6, "R10");
        t_rd(1, 8'hA5, "R9");
        // R2: command port reads zero
        t_rd(3, 8'h00, "R2");
        // R9: count-only read-back of ch1
        t_cmd(8'hD4, 9'b0, "R9");
        t_idle;
        cnt1 = 16'h0101;
        t_rd(1, 8'hA5, "R9");
        t_rd(1, 8'h01, "R9");
        t_idle;
        t_idle;
        t_idle;
        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard: got %0d left exp 0", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule